// File: doc/BRIEF.md
# Paged Cartridge Memory Address Decoder

This block sits between a home-computer expansion bus and one 128K x 8 static RAM. The host offers three 1K RAM holes, three fixed 8K blocks and one extra 8K window at host $A000-$BFFF. It also has an I/O area that is used here only to load a page register. The decoder maps each of these host regions onto its own slice of the SRAM. It drives the SRAM address, the chip enable, the output enable and the write enable. All strobes are gated by the phase-2 clock.

The 8K window at $A000-$BFFF is banked. A host write into the I/O area stores the low data nibble in a 4-bit page register. The register value is placed directly on SRAM address bits 16..13 whenever the window is accessed. Values 4 to 15 select the twelve banks that fill SRAM $08000-$1FFFF. Values 0 to 3 are accepted and land on the low SRAM region, always in the same place.

The selects, strobe and data are sampled by a synchronous system clock. The clock also times the page-register update and the synchronous active-high reset. The address and strobe outputs are combinational functions of the bus inputs and the page register.

Top module: `cart_bank_decoder`

## Requirements
- R1: When exactly one hole select `hole_sel_n[k]` (k = 0, 1, 2) is low and the access is enabled, `sram_addr` = ((k+1) << 10) | host_addr[9:0]. SRAM bits 16..12 are zero.
- R2: When exactly one block select `blk_sel_n[k]` (k = 0, 1, 2) is low and the access is enabled, `sram_addr` = ((k+1) << 13) | host_addr[12:0].
- R3: When `bank_sel_n` alone is low and the access is enabled, `sram_addr` = (page << 13) | host_addr[12:0], where page is the 4-bit page register.
- R4: A write cycle (`host_rw` = 0, `phi2` = 1) while `io2_sel_n` is low captures host_data[3:0]. The captured value enters the page register on the clock edge that sees `io2_sel_n` return high. host_data[7:4] are ignored.
- R5: After reset the page register holds 4, so a window access at host $A000 addresses SRAM $08000.
- R6: Page values 0 to 3 are stored like any other value and map the window to (value << 13) | host_addr[12:0].
- R7: `sram_ce_n` is low only when exactly one of the seven memory selects is low, `io2_sel_n` is high and `phi2` is high. Two or more active selects, or an active I/O select, keep the SRAM disabled.
- R8: `sram_oe_n` is low only for an enabled read (`host_rw` = 1), and `sram_we_n` is low only for an enabled write (`host_rw` = 0). Both stay high while `phi2` is low.
- R9: A read cycle in the I/O area leaves the page register unchanged.
- R10: While `sram_ce_n` is high, `sram_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Host phase-2 clock; high during the data phase |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 16 | Host address bus |
| host_data | input | 8 | Host data bus, as seen by the decoder |
| hole_sel_n | input | 3 | Active-low selects of the three 1K RAM holes |
| blk_sel_n | input | 3 | Active-low selects of the three fixed 8K blocks |
| bank_sel_n | input | 1 | Active-low select of the banked 8K window |
| io2_sel_n | input | 1 | Active-low select of the I/O area holding the page register |
| sram_addr | output | 17 | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench builds the block with its default parameters: 10-bit holes, 13-bit blocks and a 17-bit SRAM address, which leaves a 4-bit page register. With a register that narrow, every one of the sixteen page values can be written, including the four aliasing ones and values with junk in the upper data nibble. After each write the bench sweeps the whole window. Every offset of every 1K hole is swept, and the three 8K blocks are sampled at a fine stride. Select collisions, an active I/O select, a low phase-2 clock and I/O reads are each driven next to valid accesses, so each gating rule is seen from both sides.

// File: rtl/cart_pkg.sv
package cart_pkg;

    // Width of the region index carried with a decoded select
    localparam int SEL_IDX_W = 4;

    typedef enum logic [2:0] {
        REG_NONE = 3'd0,
        REG_HOLE = 3'd1,
        REG_BLK  = 3'd2,
        REG_BANK = 3'd3
    } region_e;

    typedef struct packed {
        region_e                region;
        logic [SEL_IDX_W-1:0]   idx;
        logic                   hit;
    } sel_t;

    // Places a region code above an offset field of the given width
    function automatic logic [31:0] place_code(input logic [SEL_IDX_W-1:0] code,
                                               input int unsigned shift);
        return 32'(code) << shift;
    endfunction

endpackage

// File: rtl/cart_sel_decode.sv
module cart_sel_decode
    import cart_pkg::*;
#(
    parameter int N_HOLES = 3,
    parameter int N_BLKS  = 3
) (
    input  logic               phi2,
    input  logic [N_HOLES-1:0] hole_sel_n,
    input  logic [N_BLKS-1:0]  blk_sel_n,
    input  logic               bank_sel_n,
    input  logic               io2_sel_n,
    output sel_t               sel
);
    localparam int N_SEL = N_HOLES + N_BLKS + 1;

    logic [N_SEL-1:0] act;
    logic             single;

    assign act    = {~bank_sel_n, ~blk_sel_n, ~hole_sel_n};
    assign single = ($countones(act) == 1);

    always_comb begin
        sel        = '{region: REG_NONE, idx: '0, hit: 1'b0};
        sel.hit    = single & phi2 & io2_sel_n;
        if (sel.hit) begin
            for (int i = 0; i < N_HOLES; i++) begin
                if (!hole_sel_n[i]) begin
                    sel.region = REG_HOLE;
                    sel.idx    = SEL_IDX_W'(i + 1);
                end
            end
            for (int j = 0; j < N_BLKS; j++) begin
                if (!blk_sel_n[j]) begin
                    sel.region = REG_BLK;
                    sel.idx    = SEL_IDX_W'(j + 1);
                end
            end
            if (!bank_sel_n) begin
                sel.region = REG_BANK;
                sel.idx    = '0;
            end
        end
    end

endmodule

// File: rtl/cart_page_reg.sv
module cart_page_reg #(
    parameter int          PAGE_W     = 4,
    parameter logic [3:0]  PAGE_RESET = 4'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              host_rw,
    input  logic              io2_sel_n,
    input  logic [PAGE_W-1:0] data_lo,
    output logic [PAGE_W-1:0] page
);
    logic [PAGE_W-1:0] stage_q;
    logic              armed_q;
    logic              io2_q;
    logic              release_edge;

    assign release_edge = !io2_q && io2_sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            armed_q <= 1'b0;
            io2_q   <= 1'b1;
            page    <= PAGE_W'(PAGE_RESET);
        end else begin
            io2_q <= io2_sel_n;
            if (!io2_sel_n && !host_rw && phi2) begin
                stage_q <= data_lo;
                armed_q <= 1'b1;
            end else if (release_edge) begin
                armed_q <= 1'b0;
                if (armed_q) begin
                    page <= stage_q;
                end
            end
        end
    end

    // R4, R9: the page only moves on a release of the I/O select
    a_r4_page_only_on_release: assert property (@(posedge clk) disable iff (rst)
        !release_edge |=> $stable(page));

    // R9: a release with no write captured keeps the page
    a_r9_read_keeps_page: assert property (@(posedge clk) disable iff (rst)
        (release_edge && !armed_q) |=> $stable(page));

endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
    import cart_pkg::*;
#(
    parameter int HOST_AW = 16,
    parameter int SRAM_AW = 17,
    parameter int HOLE_AW = 10,
    parameter int BLK_AW  = 13
) (
    input  sel_t                        sel,
    input  logic [BLK_AW-1:0]           host_lo,
    input  logic [SRAM_AW-BLK_AW-1:0]   page,
    output logic [SRAM_AW-1:0]          sram_addr
);
    localparam int PAGE_W = SRAM_AW - BLK_AW;

    logic [SRAM_AW-1:0] hole_addr, blk_addr, bank_addr;

    assign hole_addr = SRAM_AW'(place_code(sel.idx, HOLE_AW))
                     | SRAM_AW'(host_lo[HOLE_AW-1:0]);
    assign blk_addr  = SRAM_AW'(place_code(sel.idx, BLK_AW))
                     | SRAM_AW'(host_lo);
    assign bank_addr = {page, host_lo};

    always_comb begin
        unique case (sel.region)
            REG_HOLE: sram_addr = hole_addr;
            REG_BLK:  sram_addr = blk_addr;
            REG_BANK: sram_addr = bank_addr;
            default:  sram_addr = '0;
        endcase
    end

endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
    import cart_pkg::*;
#(
    parameter int         HOST_AW    = 16,
    parameter int         DATA_W     = 8,
    parameter int         SRAM_AW    = 17,
    parameter int         HOLE_AW    = 10,
    parameter int         BLK_AW     = 13,
    parameter int         N_HOLES    = 3,
    parameter int         N_BLKS     = 3,
    parameter logic [3:0] PAGE_RESET = 4'd4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                phi2,
    input  logic                host_rw,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [DATA_W-1:0]   host_data,
    input  logic [N_HOLES-1:0]  hole_sel_n,
    input  logic [N_BLKS-1:0]   blk_sel_n,
    input  logic                bank_sel_n,
    input  logic                io2_sel_n,
    output logic [SRAM_AW-1:0]  sram_addr,
    output logic                sram_ce_n,
    output logic                sram_oe_n,
    output logic                sram_we_n
);
    localparam int PAGE_W = SRAM_AW - BLK_AW;

    sel_t              sel;
    logic [PAGE_W-1:0] page;
    logic              unused_hi;

    assign unused_hi = ^{host_addr[HOST_AW-1:BLK_AW], host_data[DATA_W-1:PAGE_W]};

    cart_sel_decode #(.N_HOLES(N_HOLES), .N_BLKS(N_BLKS)) u_sel (
        .phi2       (phi2),
        .hole_sel_n (hole_sel_n),
        .blk_sel_n  (blk_sel_n),
        .bank_sel_n (bank_sel_n),
        .io2_sel_n  (io2_sel_n),
        .sel        (sel)
    );

    cart_page_reg #(.PAGE_W(PAGE_W), .PAGE_RESET(PAGE_RESET)) u_page (
        .clk        (clk),
        .rst        (rst),
        .phi2       (phi2),
        .host_rw    (host_rw),
        .io2_sel_n  (io2_sel_n),
        .data_lo    (host_data[PAGE_W-1:0]),
        .page       (page)
    );

    cart_addr_map #(.HOST_AW(HOST_AW), .SRAM_AW(SRAM_AW), .HOLE_AW(HOLE_AW),
                    .BLK_AW(BLK_AW)) u_map (
        .sel        (sel),
        .host_lo    (host_addr[BLK_AW-1:0]),
        .page       (page),
        .sram_addr  (sram_addr)
    );

    assign sram_ce_n = !sel.hit;
    assign sram_oe_n = !(sel.hit && host_rw);
    assign sram_we_n = !(sel.hit && !host_rw);

    // R7: an enable needs one select, phase 2 and a quiet I/O select
    a_r7_single_enable: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> ($countones({~bank_sel_n, ~blk_sel_n, ~hole_sel_n}) == 1)
                       && phi2 && io2_sel_n);

    // R8: nothing strobes the SRAM outside phase 2
    a_r8_phi2_gate: assert property (@(posedge clk) disable iff (rst)
        !phi2 |-> (sram_ce_n && sram_oe_n && sram_we_n));

    // R8: read and write strobes never overlap
    a_r8_oe_we_excl: assert property (@(posedge clk) disable iff (rst)
        !(!sram_oe_n && !sram_we_n));

    // R10: an idle SRAM sees a zero address
    a_r10_idle_addr: assert property (@(posedge clk) disable iff (rst)
        sram_ce_n |-> (sram_addr == '0));

endmodule

// File: tb/cart_bank_decoder_tb.sv
module cart_bank_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic        host_rw = 1'b1;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic [2:0]  hole_sel_n = 3'b111;
    logic [2:0]  blk_sel_n = 3'b111;
    logic        bank_sel_n = 1'b1;
    logic        io2_sel_n = 1'b1;
    logic [16:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cart_bank_decoder u_dut (
        .clk(clk), .rst(rst), .phi2(phi2), .host_rw(host_rw),
        .host_addr(host_addr), .host_data(host_data),
        .hole_sel_n(hole_sel_n), .blk_sel_n(blk_sel_n),
        .bank_sel_n(bank_sel_n), .io2_sel_n(io2_sel_n),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        phi2 = 1'b0; host_rw = 1'b1; hole_sel_n = 3'b111; blk_sel_n = 3'b111;
        bank_sel_n = 1'b1; io2_sel_n = 1'b1;
    endtask

    task automatic drive(input logic [2:0] h_n, input logic [2:0] b_n, input logic k_n,
                         input logic i_n, input logic ph, input logic r,
                         input logic [15:0] a);
        @(negedge clk);
        hole_sel_n = h_n; blk_sel_n = b_n; bank_sel_n = k_n; io2_sel_n = i_n;
        phi2 = ph; host_rw = r; host_addr = a;
        #2;
    endtask

    // I/O cycle then release; the page is visible after the release edge
    task automatic io_cycle(input logic r, input logic [7:0] d);
        @(negedge clk);
        hole_sel_n = 3'b111; blk_sel_n = 3'b111; bank_sel_n = 1'b1;
        io2_sel_n = 1'b0; phi2 = 1'b1; host_rw = r; host_data = d; host_addr = 16'h9800;
        #2;
        chk("R7 io cycle keeps SRAM disabled", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        @(negedge clk);
        io2_sel_n = 1'b1; phi2 = 1'b0; host_rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic sweep_bank(input int pg, input string req);
        for (int off = 0; off < 8192; off += 97) begin
            drive(3'b111, 3'b111, 1'b0, 1'b1, 1'b1, 1'b1, 16'(32'hA000 + off));
            chk(req, 32'(sram_addr), (pg << 13) | off);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk("R10 idle address after reset", 32'(sram_addr), 0);
        chk("R7 idle strobes after reset", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);

        // R5: reset page is 4
        drive(3'b111, 3'b111, 1'b0, 1'b1, 1'b1, 1'b1, 16'hA000);
        chk("R5 reset page maps A000", 32'(sram_addr), 32'h08000);
        sweep_bank(4, "R5 reset page sweep");

        // R1: every offset of every hole, reads and writes
        for (int k = 0; k < 3; k++) begin
            for (int off = 0; off < 1024; off++) begin
                logic [2:0] hn;
                logic       r;
                hn = 3'b111; hn[k] = 1'b0;
                r  = off[0];
                drive(hn, 3'b111, 1'b1, 1'b1, 1'b1, r, 16'(((k + 1) << 10) + off));
                chk("R1 hole address", 32'(sram_addr), ((k + 1) << 10) | off);
                chk("R8 hole strobes", {sram_ce_n, sram_oe_n, sram_we_n},
                    r ? 3'b001 : 3'b010);
            end
        end

        // R2: the three fixed blocks
        for (int k = 0; k < 3; k++) begin
            for (int off = 0; off < 8192; off += 37) begin
                logic [2:0] bn;
                bn = 3'b111; bn[k] = 1'b0;
                drive(3'b111, bn, 1'b1, 1'b1, 1'b1, 1'b0, 16'(((k + 1) << 13) + off));
                chk("R2 block address", 32'(sram_addr), ((k + 1) << 13) | off);
                chk("R8 block write strobes", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b010);
            end
        end

        // R3, R4, R6: all sixteen page values, junk in the upper nibble
        for (int v = 0; v < 16; v++) begin
            logic [7:0] d;
            d = 8'(v) | 8'((v * 7 + 5) << 4);
            idle();
            io_cycle(1'b0, d);
            if (v < 4) sweep_bank(v, "R6 aliasing page sweep");
            else       sweep_bank(v, "R3 R4 banked page sweep");
        end

        // R9: an I/O read leaves the page alone
        idle();
        io_cycle(1'b0, 8'h09);
        io_cycle(1'b1, 8'h03);
        drive(3'b111, 3'b111, 1'b0, 1'b1, 1'b1, 1'b1, 16'hA123);
        chk("R9 page after io read", 32'(sram_addr), (9 << 13) | 32'h0123);

        // R7: collisions, active I/O select, phase-2 low
        drive(3'b110, 3'b110, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0400);
        chk("R7 two selects disable", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        chk("R10 two selects zero address", 32'(sram_addr), 0);
        drive(3'b111, 3'b111, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA000);
        chk("R7 io select blocks enable", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        drive(3'b111, 3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 16'h6000);
        chk("R8 phase-2 low blocks write", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        chk("R10 phase-2 low zero address", 32'(sram_addr), 0);
        drive(3'b111, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 16'hBFFF);
        chk("R3 window top write", 32'(sram_addr), (9 << 13) | 32'h1FFF);
        chk("R8 window write strobes", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b010);

        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule